// File: doc/BRIEF.md
# Multi-Width SPI Target Shift Interface

This block is the bit-level front end of a memory-style SPI target. While chip select is low it shifts command, address and write-data bits in on the rising edge of the serial clock and shifts read data out on the falling edge. Each byte can travel over one, two or four lanes, and a command layer above it picks the width byte by byte. That layer also flags read phases and supplies the byte to send. In return it gets each assembled byte together with a one-clock strobe. Command decoding and storage belong to that layer, not to this block.

The serial clock may idle low (mode 0) or high (mode 3) between frames. All logic runs on the serial clock itself: capture registers on its rising edge and launch registers on its falling edge. Raising chip select clears the frame logic at once, without waiting for a clock edge. Output enables are driven only during read phases, so the shared lanes never see two drivers at once.

A small state machine tracks the position inside a byte. Its states are `S_IDLE` (no bit captured since selection), `S_SHIFT` (inside a byte) and `S_DONE` (a byte was just completed and the strobe is high). On every rising edge, each state moves to `S_DONE` when that edge captures the final bit-time of the byte, and to `S_SHIFT` otherwise. Deselection or reset sends it to `S_IDLE` from any state.

Top module: `spi_lane_shifter`

## Requirements
- R1: While `rst_n` is low or `cs_n` is high, `dq_oe` is 0000 and `rx_valid` is low, and clock edges have no effect. When the target is selected again, byte assembly starts from bit-time 0, even if the previous frame ended in the middle of a byte.
- R2: Single width (`lane_w`=00) captures one bit per rising edge from `dq_i[0]`, most significant bit first, and takes 8 edges per byte. `dq_i[3:1]` are ignored.
- R3: Dual width (`lane_w`=01) captures two bits per rising edge, with the higher bit of each pair on `dq_i[1]`, and takes 4 edges per byte. `dq_i[3:2]` are ignored.
- R4: Quad width (`lane_w`=10) captures four bits per rising edge, upper nibble first with the highest bit on `dq_i[3]`, and takes 2 edges per byte.
- R5: `rx_valid` is high for exactly one clock cycle, starting at the rising edge that captures the last bit-time of a byte, and is low otherwise. While it is high, `rx_data` holds that byte, and `rx_data` keeps it until the next byte completes.
- R6: `lane_w` is sampled at the first bit-time of each byte, and the code 11 acts as single width. A change of `lane_w` later in the byte has no effect on that byte, in either direction.
- R7: Read data is launched on falling edges, most significant bit first: on `dq_o[1]` in single width, on `dq_o[1:0]` in dual width (higher bit on `dq_o[1]`), and on `dq_o[3:0]` in quad width (upper nibble first). `tx_data` is sampled at the falling edge that starts the byte, and later changes to it are ignored for that byte.
- R8: On each falling edge, `dq_oe` becomes 0010 for single width, 0011 for dual width or 1111 for quad width if `rd_phase` is high, and 0000 if `rd_phase` is low.
- R9: In mode 3, the first falling edge after selection already launches the first slice of byte 0, so a frame can start directly with read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock (mode 0 or mode 3) |
| cs_n | input | 1 | Active-low select; high clears the frame logic |
| dq_i | input | 4 | Lane input values |
| dq_o | output | 4 | Lane output values |
| dq_oe | output | 4 | Per-lane output enables |
| lane_w | input | 2 | Width for the current byte: 00 single, 01 dual, 10 quad |
| rd_phase | input | 1 | Command layer flags a read-out phase |
| tx_data | input | DATA_W | Byte to serialise |
| rx_data | output | DATA_W | Last assembled byte |
| rx_valid | output | 1 | One-cycle byte-complete strobe |

## Verification
A misaligned bit counter shows up at the next byte boundary, where `rx_valid` rises on the wrong edge and `rx_data` holds bits shifted across lanes. A width register that follows `lane_w` in the middle of a byte changes the spacing of the strobes. It also changes the lane pattern on `dq_oe` half a clock after the faulty edge. A stale enable, or one not cleared on deselection, is visible on `dq_oe` right after `cs_n` rises or at the next falling edge. The bench sweeps every byte value at every width and changes the width control and the transmit byte in the middle of each byte, so these faults reach the ports within one byte.

// File: rtl/sls_pkg.sv
`timescale 1ns/1ps
package sls_pkg;

    localparam int LANES = 4;

    // Lane-width codes carried on the lane_w port
    typedef enum logic [1:0] {
        LW_ONE  = 2'b00,
        LW_TWO  = 2'b01,
        LW_FOUR = 2'b10,
        LW_RSVD = 2'b11
    } lane_w_t;

    // Position of the frame inside a byte
    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_SHIFT = 2'b01,
        S_DONE  = 2'b10
    } frm_state_t;

    // Reserved code falls back to single width
    function automatic lane_w_t norm_w(input logic [1:0] raw);
        lane_w_t w;
        unique case (raw)
            2'b01:   w = LW_TWO;
            2'b10:   w = LW_FOUR;
            default: w = LW_ONE;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/sls_frame_fsm.sv
`timescale 1ns/1ps
module sls_frame_fsm
    import sls_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int CNT_W  = $clog2(DATA_W)
) (
    input  logic             sck,
    input  logic             clr_n,
    input  logic [1:0]       lane_w_raw,
    output lane_w_t          eff_w,
    output logic [CNT_W-1:0] bit_idx,
    output logic             last_bit,
    output logic             byte_done
);

    localparam int STEPS_ONE  = DATA_W;
    localparam int STEPS_TWO  = DATA_W / 2;
    localparam int STEPS_FOUR = DATA_W / 4;

    frm_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;
    lane_w_t          w_q;

    // Width is taken live at bit-time zero, then held for the byte
    always_comb begin
        eff_w = (cnt_q == '0) ? norm_w(lane_w_raw) : w_q;
        unique case (eff_w)
            LW_TWO:  last_idx = CNT_W'(STEPS_TWO - 1);
            LW_FOUR: last_idx = CNT_W'(STEPS_FOUR - 1);
            default: last_idx = CNT_W'(STEPS_ONE - 1);
        endcase
        last_bit = (cnt_q == last_idx);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = last_bit ? S_DONE : S_SHIFT;
            S_SHIFT: state_d = last_bit ? S_DONE : S_SHIFT;
            S_DONE:  state_d = last_bit ? S_DONE : S_SHIFT;
            default: state_d = S_IDLE;
        endcase
    end

    // State register, bit counter, held width
    always_ff @(posedge sck or negedge clr_n) begin
        if (!clr_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            w_q     <= LW_ONE;
        end else begin
            state_q <= state_d;
            cnt_q   <= last_bit ? '0 : cnt_q + CNT_W'(1);
            w_q     <= eff_w;
        end
    end

    // Outputs
    always_comb begin
        byte_done = (state_q == S_DONE);
        bit_idx   = cnt_q;
    end

endmodule

// File: rtl/sls_rx_assembler.sv
`timescale 1ns/1ps
module sls_rx_assembler
    import sls_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              sck,
    input  logic              clr_n,
    input  logic              rst_n,
    input  logic [LANES-1:0]  dq_i,
    input  lane_w_t           eff_w,
    input  logic              last_bit,
    output logic [DATA_W-1:0] rx_data
);

    logic [DATA_W-1:0] asm_q, asm_d;

    // Shift in one, two or four bits, most significant first
    always_comb begin
        unique case (eff_w)
            LW_TWO:  asm_d = {asm_q[DATA_W-3:0], dq_i[1:0]};
            LW_FOUR: asm_d = {asm_q[DATA_W-5:0], dq_i[3:0]};
            default: asm_d = {asm_q[DATA_W-2:0], dq_i[0]};
        endcase
    end

    always_ff @(posedge sck or negedge clr_n) begin
        if (!clr_n) asm_q <= '0;
        else        asm_q <= asm_d;
    end

    // Completed byte survives deselection
    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n)        rx_data <= '0;
        else if (last_bit) rx_data <= asm_d;
    end

endmodule

// File: rtl/sls_tx_serializer.sv
`timescale 1ns/1ps
module sls_tx_serializer
    import sls_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int CNT_W  = $clog2(DATA_W)
) (
    input  logic              sck,
    input  logic              clr_n,
    input  logic [CNT_W-1:0]  bit_idx,
    input  lane_w_t           eff_w,
    input  logic              rd_phase,
    input  logic [DATA_W-1:0] tx_data,
    output logic [LANES-1:0]  dq_o,
    output logic [LANES-1:0]  dq_oe
);

    logic [DATA_W-1:0] hold_q, src, shifted;
    logic [LANES-1:0]  slice_d, mask_d;

    always_comb begin
        src = (bit_idx == '0) ? tx_data : hold_q;
        unique case (eff_w)
            LW_TWO: begin
                shifted = src << {bit_idx, 1'b0};
                slice_d = {2'b00, shifted[DATA_W-1 -: 2]};
                mask_d  = 4'b0011;
            end
            LW_FOUR: begin
                shifted = src << {bit_idx, 2'b00};
                slice_d = shifted[DATA_W-1 -: 4];
                mask_d  = 4'b1111;
            end
            default: begin
                shifted = src << bit_idx;
                slice_d = {2'b00, shifted[DATA_W-1], 1'b0};
                mask_d  = 4'b0010;
            end
        endcase
    end

    // Launch on the falling edge
    always_ff @(negedge sck or negedge clr_n) begin
        if (!clr_n) begin
            hold_q <= '0;
            dq_o   <= '0;
            dq_oe  <= '0;
        end else begin
            if (bit_idx == '0) hold_q <= tx_data;
            dq_o  <= slice_d;
            dq_oe <= rd_phase ? mask_d : '0;
        end
    end

endmodule

// File: rtl/spi_lane_shifter.sv
`timescale 1ns/1ps
module spi_lane_shifter
    import sls_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int CNT_W  = $clog2(DATA_W)
) (
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic [LANES-1:0]  dq_i,
    output logic [LANES-1:0]  dq_o,
    output logic [LANES-1:0]  dq_oe,
    input  logic [1:0]        lane_w,
    input  logic              rd_phase,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    logic             clr_n;
    lane_w_t          eff_w;
    logic [CNT_W-1:0] bit_idx;
    logic             last_bit;

    assign clr_n = rst_n & ~cs_n;

    sls_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .sck        (sck),
        .clr_n      (clr_n),
        .lane_w_raw (lane_w),
        .eff_w      (eff_w),
        .bit_idx    (bit_idx),
        .last_bit   (last_bit),
        .byte_done  (rx_valid)
    );

    sls_rx_assembler #(.DATA_W(DATA_W)) u_rx (
        .sck      (sck),
        .clr_n    (clr_n),
        .rst_n    (rst_n),
        .dq_i     (dq_i),
        .eff_w    (eff_w),
        .last_bit (last_bit),
        .rx_data  (rx_data)
    );

    sls_tx_serializer #(.DATA_W(DATA_W)) u_tx (
        .sck      (sck),
        .clr_n    (clr_n),
        .bit_idx  (bit_idx),
        .eff_w    (eff_w),
        .rd_phase (rd_phase),
        .tx_data  (tx_data),
        .dq_o     (dq_o),
        .dq_oe    (dq_oe)
    );

endmodule

// File: rtl/sls_checker.sv
`timescale 1ns/1ps
module sls_checker #(
    parameter int DATA_W = 8
) (
    input logic              rst_n,
    input logic              sck,
    input logic              cs_n,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic [3:0]        dq_oe
);

    logic       clr_n;
    logic [4:0] edge_cnt_q;

    assign clr_n = rst_n & ~cs_n;

    // Rising edges since the last strobe (saturating)
    always_ff @(posedge sck or negedge clr_n) begin
        if (!clr_n)                  edge_cnt_q <= '0;
        else if (rx_valid)           edge_cnt_q <= 5'd1;
        else if (edge_cnt_q != 5'd31) edge_cnt_q <= edge_cnt_q + 5'd1;
    end

    p_deselect_quiet_r1: assert property (@(posedge sck) disable iff (!rst_n)
        cs_n |-> (dq_oe == 4'b0000 && !rx_valid));

    p_strobe_one_cycle_r5: assert property (@(posedge sck) disable iff (!clr_n)
        rx_valid |=> !rx_valid);

    p_data_held_r5: assert property (@(posedge sck) disable iff (!clr_n)
        rx_valid |=> $stable(rx_data));

    p_byte_len_r6: assert property (@(posedge sck) disable iff (!clr_n)
        rx_valid |-> (edge_cnt_q == 5'(DATA_W) || edge_cnt_q == 5'(DATA_W / 2)
                      || edge_cnt_q == 5'(DATA_W / 4)));

    p_oe_pattern_r8: assert property (@(negedge sck) disable iff (!clr_n)
        (dq_oe == 4'b0000 || dq_oe == 4'b0010 || dq_oe == 4'b0011 || dq_oe == 4'b1111));

endmodule

bind spi_lane_shifter sls_checker #(.DATA_W(DATA_W)) u_sls_chk (
    .rst_n    (rst_n),
    .sck      (sck),
    .cs_n     (cs_n),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .dq_oe    (dq_oe)
);

// File: tb/spi_lane_shifter_bench.sv
`timescale 1ns/1ps
module spi_lane_shifter_bench;

    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic [3:0] dq_i = 4'h0;
    logic [1:0] lane_w = 2'b00;
    logic       rd_phase = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [3:0] dq_o, dq_oe;
    logic [7:0] rx_data;
    logic       rx_valid;

    int n_chk = 0;
    int n_err = 0;

    int         f_n;
    logic [1:0] f_w   [0:299];
    logic       f_rd  [0:299];
    logic [7:0] f_tx  [0:299];
    logic [7:0] f_din [0:299];

    spi_lane_shifter u_spi_lane_shifter (
        .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .dq_i(dq_i), .dq_o(dq_o),
        .dq_oe(dq_oe), .lane_w(lane_w), .rd_phase(rd_phase), .tx_data(tx_data),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lanes_n(input logic [1:0] w);
        case (w)
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [3:0] oe_mask(input logic [1:0] w);
        case (lanes_n(w))
            2:       return 4'b0011;
            4:       return 4'b1111;
            default: return 4'b0010;
        endcase
    endfunction

    function automatic logic [3:0] chunk(input logic [7:0] v, input int k, input int n);
        logic [7:0] s;
        s = v >> (8 - n * (k + 1));
        return 4'(s & 8'((1 << n) - 1));
    endfunction

    task automatic run_frame(input bit m3);
        sck = m3;
        #1.25;
        lane_w = f_w[0]; rd_phase = f_rd[0]; tx_data = f_tx[0];
        cs_n = 1'b0;
        #1.25;
        for (int b = 0; b < f_n; b++) begin
            int n;
            int st;
            string tagw;
            n = lanes_n(f_w[b]);
            st = 8 / n;
            tagw = (f_w[b] == 2'b00) ? "R2" : (f_w[b] == 2'b01) ? "R3" :
                   (f_w[b] == 2'b10) ? "R4" : "R6";
            for (int k = 0; k < st; k++) begin
                logic [3:0] c, noise, exp_oe, exp_o;
                bit launched;
                c = chunk(f_din[b], k, n);
                noise = 4'(k * 7 + b * 3) ^ 4'hA;
                sck = 1'b0;
                if (n == 1)      dq_i = {noise[3:1], c[0]};
                else if (n == 2) dq_i = {noise[3:2], c[1:0]};
                else             dq_i = c;
                #1.25;
                // outputs for this bit-time (launched at the preceding falling edge)
                launched = !(b == 0 && k == 0 && !m3);
                exp_oe = (launched && f_rd[b]) ? oe_mask(f_w[b]) : 4'b0000;
                check(dq_oe == exp_oe, (b == 0 && k == 0) ? "R9 oe" : "R8 oe", dq_oe, exp_oe);
                if (exp_oe != 4'b0000) begin
                    c = chunk(f_tx[b], k, n);
                    exp_o = (n == 1) ? {2'b00, c[0], 1'b0} : c;
                    check((dq_o & exp_oe) == exp_o, (b == 0 && k == 0) ? "R9 data" : "R7 data",
                          dq_o & exp_oe, exp_o);
                end
                #1.25;
                sck = 1'b1;
                #1.25;
                check(rx_valid == (k == st - 1), "R5 strobe", rx_valid, (k == st - 1));
                if (k == st - 1) begin
                    check(rx_data == f_din[b], tagw, rx_data, f_din[b]);
                    if (b + 1 < f_n) begin
                        lane_w = f_w[b + 1]; rd_phase = f_rd[b + 1]; tx_data = f_tx[b + 1];
                    end
                end else begin
                    // R6/R7: mid-byte changes must be ignored
                    lane_w = (f_w[b] == 2'b10) ? 2'b00 : f_w[b] + 2'b01;
                    tx_data = ~f_tx[b];
                end
                #1.25;
            end
        end
        if (!m3) begin
            sck = 1'b0;
            #1.25;
        end
        cs_n = 1'b1;
        #1.25;
        check(dq_oe == 4'b0000, "R1 oe after deselect", dq_oe, 0);
        check(rx_valid == 1'b0, "R1 strobe after deselect", rx_valid, 0);
        #2.5;
    endtask

    initial begin
        #1000000;
        n_err++;
        n_chk++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #10;
        rst_n = 1'b1;
        #5;
        check(dq_oe == 4'b0000, "R1 reset oe", dq_oe, 0);
        check(rx_valid == 1'b0, "R1 reset strobe", rx_valid, 0);
        check(rx_data == 8'h00, "R1 reset data", rx_data, 0);

        // clock edges while deselected
        rd_phase = 1'b1; lane_w = 2'b10;
        for (int i = 0; i < 3; i++) begin
            sck = 1'b1; #2.5; sck = 1'b0; #2.5;
        end
        check(dq_oe == 4'b0000, "R1 deselected edges oe", dq_oe, 0);
        check(rx_valid == 1'b0, "R1 deselected edges strobe", rx_valid, 0);

        // exhaustive byte sweep per width
        for (int w = 0; w < 3; w++) begin
            f_n = 257;
            f_w[0] = 2'b00; f_rd[0] = 1'b0; f_tx[0] = 8'h00; f_din[0] = 8'hEB;
            for (int b = 1; b < 257; b++) begin
                f_w[b] = 2'(w);
                f_rd[b] = b[0];
                f_din[b] = 8'(b - 1);
                f_tx[b] = 8'(b - 1) ^ 8'h3C;
            end
            run_frame(w[0]);
        end

        // mixed widths inside a frame, both modes
        for (int m = 0; m < 2; m++) begin
            f_n = 24;
            for (int b = 0; b < 24; b++) begin
                f_w[b] = 2'(b % 4);
                f_rd[b] = (b % 3 == 0) && (m == 1 || b != 0);
                f_din[b] = 8'(b * 37 + 11);
                f_tx[b] = 8'(b * 53 + 7);
            end
            run_frame(m[0]);
        end

        // abort mid-byte, then a fresh frame must realign (R1)
        sck = 1'b0; #1.25;
        lane_w = 2'b00; rd_phase = 1'b1; tx_data = 8'hFF;
        cs_n = 1'b0; #1.25;
        for (int i = 0; i < 3; i++) begin
            dq_i = 4'h1; sck = 1'b1; #2.5; sck = 1'b0; #2.5;
        end
        check(dq_oe == 4'b0010, "R8 oe before abort", dq_oe, 4'b0010);
        cs_n = 1'b1;
        #1;
        check(dq_oe == 4'b0000, "R1 oe released on abort", dq_oe, 0);
        #1.5;
        f_n = 3;
        f_w[0] = 2'b00; f_rd[0] = 1'b0; f_tx[0] = 8'h00; f_din[0] = 8'h96;
        f_w[1] = 2'b10; f_rd[1] = 1'b1; f_tx[1] = 8'hC3; f_din[1] = 8'h5A;
        f_w[2] = 2'b01; f_rd[2] = 1'b1; f_tx[2] = 8'h81; f_din[2] = 8'h7E;
        run_frame(1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule